// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Controller

This block sits next to a processor core and turns raw comparator match pulses into three kinds of debug output. The first is a breakpoint request to the core. The second is a set of watchpoint pins, one per comparator. The third is a set of counter-expired flags. Each comparator can trap to the core when it is enabled. A comparator is enabled by a bit that software writes or by a bit that the serial debug port writes; either one is enough.

The core reports whether its machine state is currently recoverable. In the default masked mode, breakpoints from the comparators, and decrements of the watchpoint counters, happen only while the core is recoverable. A programmable non-masked mode removes that gate. Watchpoint pins are never gated.

Two external breakpoint inputs are provided:
- a maskable one, which obeys the recoverable-state rule;
- a non-maskable one, which always traps.

Counter k counts matches of comparator k, so the number of counters must not exceed the number of comparators. A counter is loaded through a write strobe. When it counts down to zero it raises a breakpoint and sets its expired flag.

Top module: `dbg_trap_ctrl`

## Requirements
- R1: A comparator match produces a breakpoint event only when that comparator's software enable or debug-port enable is 1. With both enables at 0 the match raises no breakpoint.
- R2: With `unmasked_mode`=0, an enabled comparator match raises a breakpoint only when `recov_ok`=1. A match while `recov_ok`=0 is discarded.
- R3: With `unmasked_mode`=1, an enabled comparator match raises a breakpoint whatever the value of `recov_ok`.
- R4: `ext_bp_mask`=1 raises a breakpoint only when `recov_ok`=1, whatever the value of `unmasked_mode`.
- R5: `ext_bp_nmi`=1 always raises a breakpoint; `bp_req` is 1 in the following cycle.
- R6: `wp_pins[i]` equals `cmp_hit[i]` delayed by exactly one cycle. This holds independently of the enables, `recov_ok` and `unmasked_mode`.
- R7: Counter k decrements by one on `cmp_hit[k]` only when `unmasked_mode`=1 or `recov_ok`=1, and only while its value is nonzero. Otherwise it holds its value.
- R8: `cnt_wr[k]`=1 loads counter k with `cnt_wdata` and clears `cnt_expired[k]`. A write takes priority over a match in the same cycle.
- R9: A decrement from 1 to 0 sets `cnt_expired[k]` in the next cycle and raises a breakpoint. The counter then stays at 0 and raises nothing further until it is reloaded.
- R10: Once set, `bp_req` stays 1 until a cycle with `bp_ack`=1. If no new event arrives in that cycle, `bp_req` is 0 next cycle. An event in the ack cycle keeps `bp_req` at 1.
- R11: While `rst`=1, `bp_req`, `wp_pins` and `cnt_expired` are 0 and every counter is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_hit | input | N_CMP | Per-comparator match pulses |
| sw_trap_en | input | N_CMP | Trap enables written by software |
| port_trap_en | input | N_CMP | Trap enables written by the debug port |
| recov_ok | input | 1 | Core state is recoverable |
| unmasked_mode | input | 1 | 1 = comparator breakpoints and counters ignore `recov_ok` |
| ext_bp_mask | input | 1 | Maskable external breakpoint |
| ext_bp_nmi | input | 1 | Non-maskable external breakpoint |
| cnt_wr | input | N_CNT | Per-counter load strobes |
| cnt_wdata | input | CNT_W | Counter load value |
| bp_ack | input | 1 | Core acknowledge pulse for the breakpoint request |
| bp_req | output | 1 | Breakpoint request level to the core |
| wp_pins | output | N_CMP | Registered watchpoint pulses |
| cnt_expired | output | N_CNT | Counter reached zero since its last load |

## Verification
The hardest case to reach is the frozen counter. A counter that was loaded, then received matches while masked and non-recoverable, must expire exactly as many qualified matches later as it would have without those masked matches. Counter values are visible only through the expiry timing.

To reach this case, random stimulus loads counters with values from 0 to 3 and toggles `recov_ok` and `unmasked_mode` every cycle. A bench model predicts the exact expiry cycle. A directed sweep then covers every combination of recoverable bit, mask mode and enable source, with a counter preset to 1, so that each combination decides whether an expiry and a breakpoint appear. A further directed case presents a write and a match to the same counter in one cycle.

// File: rtl/dbg_trap_pkg.sv
package dbg_trap_pkg;
  // Per-counter command formed in the top level each cycle
  typedef struct packed {
    logic load;   // reload from write data
    logic step;   // qualified watchpoint event
  } cnt_cmd_t;
endpackage

// File: rtl/dbg_trap_qual.sv
module dbg_trap_qual #(
  parameter int N_CMP = 4
) (
  input  logic [N_CMP-1:0] cmp_hit,
  input  logic [N_CMP-1:0] sw_trap_en,
  input  logic [N_CMP-1:0] port_trap_en,
  input  logic             recov_ok,
  input  logic             unmasked_mode,
  input  logic             ext_bp_mask,
  input  logic             ext_bp_nmi,
  output logic             cnt_gate,
  output logic             src_evt
);
  logic [N_CMP-1:0] armed;
  logic             cmp_evt;

  always_comb cnt_gate = unmasked_mode | recov_ok;

  for (genvar i = 0; i < N_CMP; i++) begin : g_arm
    assign armed[i] = cmp_hit[i] & (sw_trap_en[i] | port_trap_en[i]);
  end

  always_comb begin
    cmp_evt = (|armed) & cnt_gate;
    src_evt = cmp_evt | (ext_bp_mask & recov_ok) | ext_bp_nmi;
  end
endmodule

// File: rtl/dbg_wp_counter.sv
module dbg_wp_counter
  import dbg_trap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_cmd_t         cmd,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] value,
  output logic             expire_evt,
  output logic             expired
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic at_one;

  always_comb begin
    at_one     = (value == ONE);
    expire_evt = !cmd.load && cmd.step && at_one;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value   <= '0;
      expired <= 1'b0;
    end else if (cmd.load) begin
      value   <= load_val;
      expired <= 1'b0;
    end else if (cmd.step && value != '0) begin
      value <= value - ONE;
      if (at_one) expired <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_bp_latch.sv
module dbg_bp_latch (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic ack,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= (req & ~ack) | evt;
  end
endmodule

// File: rtl/dbg_trap_ctrl.sv
module dbg_trap_ctrl
  import dbg_trap_pkg::*;
#(
  parameter int N_CMP = 4,
  parameter int N_CNT = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CMP-1:0] cmp_hit,
  input  logic [N_CMP-1:0] sw_trap_en,
  input  logic [N_CMP-1:0] port_trap_en,
  input  logic             recov_ok,
  input  logic             unmasked_mode,
  input  logic             ext_bp_mask,
  input  logic             ext_bp_nmi,
  input  logic [N_CNT-1:0] cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             bp_ack,
  output logic             bp_req,
  output logic [N_CMP-1:0] wp_pins,
  output logic [N_CNT-1:0] cnt_expired
);
  localparam int FLAT_W = N_CNT * CNT_W;

  logic              cnt_gate;
  logic              src_evt;
  logic [N_CNT-1:0]  exp_evt;
  logic              bp_evt_all;
  logic [FLAT_W-1:0] cnt_q_flat;

  dbg_trap_qual #(.N_CMP(N_CMP)) qual_i (
    .cmp_hit      (cmp_hit),
    .sw_trap_en   (sw_trap_en),
    .port_trap_en (port_trap_en),
    .recov_ok     (recov_ok),
    .unmasked_mode(unmasked_mode),
    .ext_bp_mask  (ext_bp_mask),
    .ext_bp_nmi   (ext_bp_nmi),
    .cnt_gate     (cnt_gate),
    .src_evt      (src_evt)
  );

  // Counter k follows comparator k
  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    cnt_cmd_t         cmd;
    logic [CNT_W-1:0] val;
    always_comb begin
      cmd.load = cnt_wr[k];
      cmd.step = cmp_hit[k] & cnt_gate;
    end
    dbg_wp_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk       (clk),
      .rst       (rst),
      .cmd       (cmd),
      .load_val  (cnt_wdata),
      .value     (val),
      .expire_evt(exp_evt[k]),
      .expired   (cnt_expired[k])
    );
    assign cnt_q_flat[k*CNT_W +: CNT_W] = val;
  end

  always_comb bp_evt_all = src_evt | (|exp_evt);

  dbg_bp_latch latch_i (
    .clk(clk),
    .rst(rst),
    .evt(bp_evt_all),
    .ack(bp_ack),
    .req(bp_req)
  );

  // Watchpoint pins: never gated
  always_ff @(posedge clk) begin
    if (rst) wp_pins <= '0;
    else     wp_pins <= cmp_hit;
  end
endmodule

// File: rtl/dbg_trap_ctrl_chk.sv
module dbg_trap_ctrl_chk #(
  parameter int N_CMP = 4,
  parameter int N_CNT = 2,
  parameter int CNT_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic [N_CMP-1:0]       cmp_hit,
  input logic                   recov_ok,
  input logic                   unmasked_mode,
  input logic                   ext_bp_nmi,
  input logic [N_CNT-1:0]       cnt_wr,
  input logic                   bp_ack,
  input logic                   bp_req,
  input logic [N_CMP-1:0]       wp_pins,
  input logic [N_CNT-1:0]       cnt_expired,
  input logic [N_CNT*CNT_W-1:0] cnt_q_flat,
  input logic                   bp_evt_all
);
  a_r2_masked_drop: assert property (@(posedge clk) disable iff (rst)
    (!unmasked_mode && !recov_ok && !ext_bp_nmi && !bp_req) |=> !bp_req);

  a_r5_nmi_always: assert property (@(posedge clk) disable iff (rst)
    ext_bp_nmi |=> bp_req);

  a_r6_wp_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wp_pins == $past(cmp_hit)));

  a_r7_cnt_frozen: assert property (@(posedge clk) disable iff (rst)
    (!unmasked_mode && !recov_ok && cnt_wr == '0) |=>
      ($stable(cnt_q_flat) && $stable(cnt_expired)));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (bp_req && !bp_ack) |=> bp_req);

  a_r10_ack_clear: assert property (@(posedge clk) disable iff (rst)
    (bp_ack && !bp_evt_all) |=> !bp_req);
endmodule

bind dbg_trap_ctrl dbg_trap_ctrl_chk #(
  .N_CMP(N_CMP), .N_CNT(N_CNT), .CNT_W(CNT_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cmp_hit      (cmp_hit),
  .recov_ok     (recov_ok),
  .unmasked_mode(unmasked_mode),
  .ext_bp_nmi   (ext_bp_nmi),
  .cnt_wr       (cnt_wr),
  .bp_ack       (bp_ack),
  .bp_req       (bp_req),
  .wp_pins      (wp_pins),
  .cnt_expired  (cnt_expired),
  .cnt_q_flat   (cnt_q_flat),
  .bp_evt_all   (bp_evt_all)
);

// File: tb/dbg_trap_ctrl_tb_top.sv
module dbg_trap_ctrl_tb_top;
  localparam int N_CMP = 4;
  localparam int N_CNT = 2;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst;
  logic [N_CMP-1:0] cmp_hit, sw_trap_en, port_trap_en;
  logic             recov_ok, unmasked_mode, ext_bp_mask, ext_bp_nmi, bp_ack;
  logic [N_CNT-1:0] cnt_wr;
  logic [CNT_W-1:0] cnt_wdata;
  logic             bp_req;
  logic [N_CMP-1:0] wp_pins;
  logic [N_CNT-1:0] cnt_expired;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // reference state
  logic             m_bp;
  logic [N_CMP-1:0] m_wp;
  logic [N_CNT-1:0] m_exp;
  logic [CNT_W-1:0] m_cnt [N_CNT];

  always #2 clk = ~clk;

  dbg_trap_ctrl #(.N_CMP(N_CMP), .N_CNT(N_CNT), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .cmp_hit(cmp_hit), .sw_trap_en(sw_trap_en),
    .port_trap_en(port_trap_en), .recov_ok(recov_ok),
    .unmasked_mode(unmasked_mode), .ext_bp_mask(ext_bp_mask),
    .ext_bp_nmi(ext_bp_nmi), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .bp_ack(bp_ack), .bp_req(bp_req), .wp_pins(wp_pins),
    .cnt_expired(cnt_expired)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      errors = errors + 1;
      $display("FAIL watchdog: expired after %0d cycles, expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic gate_of(input logic um, input logic rv);
    return um | rv;
  endfunction

  // advance the reference model by one clock using the current inputs
  task automatic model_step();
    logic evt;
    logic g;
    g   = gate_of(unmasked_mode, recov_ok);
    evt = ((|(cmp_hit & (sw_trap_en | port_trap_en))) & g)   // R1 R2 R3
        | (ext_bp_mask & recov_ok)                             // R4
        | ext_bp_nmi;                                          // R5
    for (int k = 0; k < N_CNT; k++) begin
      if (cnt_wr[k]) begin                                     // R8
        m_cnt[k] = cnt_wdata;
        m_exp[k] = 1'b0;
      end else if (cmp_hit[k] && g && m_cnt[k] != '0) begin    // R7
        m_cnt[k] = m_cnt[k] - 1'b1;
        if (m_cnt[k] == '0) begin                              // R9
          m_exp[k] = 1'b1;
          evt = 1'b1;
        end
      end
    end
    m_bp = (m_bp & ~bp_ack) | evt;                             // R10
    m_wp = cmp_hit;                                            // R6
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R10 bp_req (R1 R2 R3 R4 R5 R9)", {31'd0, bp_req}, {31'd0, m_bp});
    check("R6 wp_pins", {28'd0, wp_pins}, {28'd0, m_wp});
    check("R7 R8 R9 cnt_expired", {30'd0, cnt_expired}, {30'd0, m_exp});
  endtask

  task automatic quiet();
    cmp_hit = '0; sw_trap_en = '0; port_trap_en = '0; recov_ok = 1'b0;
    unmasked_mode = 1'b0; ext_bp_mask = 1'b0; ext_bp_nmi = 1'b0;
    cnt_wr = '0; cnt_wdata = '0; bp_ack = 1'b0;
  endtask

  initial begin
    quiet();
    cmp_hit = '1; ext_bp_nmi = 1'b1; recov_ok = 1'b1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: outputs idle during reset despite active inputs
    check("R11 bp_req", {31'd0, bp_req}, 32'd0);
    check("R11 wp_pins", {28'd0, wp_pins}, 32'd0);
    check("R11 cnt_expired", {30'd0, cnt_expired}, 32'd0);
    quiet();
    rst = 1'b0;
    m_bp = 1'b0; m_wp = '0; m_exp = '0;
    for (int k = 0; k < N_CNT; k++) m_cnt[k] = '0;
    cyc();
    // R11: cleared counters do not expire on hits
    cmp_hit = 4'b0011; recov_ok = 1'b1; cyc();
    check("R11 counters cleared", {30'd0, cnt_expired}, 32'd0);

    // directed sweep: recov x mode x enable source
    for (int rv = 0; rv < 2; rv++)
      for (int um = 0; um < 2; um++)
        for (int src = 0; src < 4; src++) begin
          quiet(); bp_ack = 1'b1; cyc();
          quiet(); cnt_wr = 2'b01; cnt_wdata = 16'd1; cyc();
          quiet();
          recov_ok = rv[0]; unmasked_mode = um[0];
          sw_trap_en = {2'b00, src[0], 1'b0};
          port_trap_en = {2'b00, src[1], 1'b0};
          cmp_hit = 4'b0010;
          cyc();
          // R1 R2 R3: comparator 1 alone
          check("R1 R2 R3 sweep bp", {31'd0, bp_req},
                {31'd0, (src != 0) && (rv == 1 || um == 1)});
          // R7 R9: counter 0 preset to 1
          cmp_hit = 4'b0001; sw_trap_en = '0; port_trap_en = '0;
          cyc();
          check("R7 R9 sweep expiry", {31'd0, cnt_expired[0]},
                {31'd0, rv == 1 || um == 1});
          check("R6 sweep wp", {28'd0, wp_pins}, 32'd1);
        end

    // R4: maskable external ignores non-masked mode
    quiet(); bp_ack = 1'b1; cyc();
    quiet(); unmasked_mode = 1'b1; ext_bp_mask = 1'b1; cyc();
    check("R4 ext masked with recov=0", {31'd0, bp_req}, 32'd0);
    // R5: non-maskable external
    quiet(); ext_bp_nmi = 1'b1; cyc();
    check("R5 nmi", {31'd0, bp_req}, 32'd1);
    // R10: ack together with event keeps request
    quiet(); bp_ack = 1'b1; ext_bp_nmi = 1'b1; cyc();
    check("R10 ack+evt", {31'd0, bp_req}, 32'd1);
    // R8: write wins over same-cycle hit
    quiet(); cnt_wr = 2'b10; cnt_wdata = 16'd2; cmp_hit = 4'b0010; recov_ok = 1'b1; cyc();
    quiet(); cmp_hit = 4'b0010; recov_ok = 1'b1; cyc();
    check("R8 write priority", {31'd0, cnt_expired[1]}, 32'd0);
    cyc();
    check("R9 expire after 2", {31'd0, cnt_expired[1]}, 32'd1);

    // constrained random
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      cmp_hit       = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
      sw_trap_en    = 4'($urandom);
      port_trap_en  = 4'($urandom) & 4'($urandom);
      recov_ok      = 1'($urandom);
      unmasked_mode = (($urandom % 4) == 0);
      ext_bp_mask   = (($urandom % 12) == 0);
      ext_bp_nmi    = (($urandom % 30) == 0);
      bp_ack        = (($urandom % 3) == 0);
      cnt_wr        = (($urandom % 10) == 0) ? 2'($urandom) : 2'd0;
      cnt_wdata     = 16'($urandom % 4);
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule